// File: doc/BRIEF.md
# 8B/10B Receive Link Synchronization Monitor

This block decides whether an 8B/10B receive lane is in step with the far end. It does not see the symbols themselves. For every received symbol it gets three flags from the decoder and word aligner: the alignment comma was seen, the code group is a legal one, and the running disparity was broken. From these flags it runs a hunt / lock / error-region state machine with hysteresis, and it drives one sync status bit.

The datapath carries one or two 10-bit symbols per clock, set by a parameter. With two symbols per clock, both are applied in the same cycle, lower lane first. To gain lock, a run of good commas must arrive. To lose lock, errors must pile up. Each block of consecutive clean words forgives one error, so short error bursts on a live link do not drop sync. The three thresholds are parameters. Downstream logic gates its received data on the sync status bit.

Top module: `sync8b10b_fsm`

## Requirements
- R1: While reset is asserted, and after it is released, the block sits in hunt with every counter at zero and `sync_o` low.
- R2: A symbol is an error when its code-valid flag is low, or when its disparity-error flag is high, or both. A comma flag on such a symbol does not make it a pattern.
- R3: In hunt, each pattern symbol increments the pattern count. A pattern symbol is comma high, code valid high and no disparity error. The GAIN_CNT-th pattern takes the block to lock, and `sync_o` is high from the next clock edge.
- R4: In hunt, a valid non-comma symbol leaves the pattern count unchanged. An error symbol clears the pattern count to zero.
- R5: While synchronized, each error symbol increments the error count and clears the clean-word run. `sync_o` stays high as long as the error count is below LOSE_CNT.
- R6: The error that brings the error count to LOSE_CNT sends the block back to hunt. It clears all counters, and `sync_o` goes low from the next edge. Lock then again needs GAIN_CNT fresh patterns.
- R7: While the error count is non-zero, every DEC_CNT consecutive valid symbols decrement it by one. When it reaches zero, the block is back in clean lock, and LOSE_CNT new errors are again needed to lose sync.
- R8: An error symbol restarts the count of consecutive valid symbols, so valid symbols seen before an error never add to a later decrement.
- R9: With SYM_PER_CYC = 2, the lane-0 symbol (bit 0 of each flag vector) is applied before the lane-1 symbol in the same cycle. Each symbol updates the counters and the state in turn.
- R10: GAIN_CNT, LOSE_CNT and DEC_CNT are parameters in the range 1 to 256, each defaulting to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sym_comma_i | input | SYM_PER_CYC | Per-symbol flag: alignment comma detected |
| sym_code_ok_i | input | SYM_PER_CYC | Per-symbol flag: code group is legal |
| sym_disp_err_i | input | SYM_PER_CYC | Per-symbol flag: running disparity violated |
| sync_o | output | 1 | High while the link is synchronized, including the error region |

## Verification
The bench targets these corner cases:

- **Forgiveness window.** A design that never decrements the error count loses sync one cycle too early. A design that leaves a partial clean run standing across an error also forgives too early, and it keeps sync where the link should drop.
- **Pattern count in hunt.** If an error does not clear the pattern count, or if a non-comma word does clear it, lock comes early or late. The same happens if a comma with a disparity error is taken as a pattern.
- **Lane order.** In a two-lane cycle whose lower symbol causes loss of sync, the upper symbol must already count toward re-acquisition. Processing the lanes in the other order, or dropping the second lane, shifts the cycle in which lock returns.

// File: rtl/sync8b10b_pkg.sv
package sync8b10b_pkg;

  // Counters cover thresholds up to 256.
  localparam int CNT_W = 9;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_LOCK = 2'd1,
    ST_ERR  = 2'd2
  } sync_st_e;

  typedef struct packed {
    sync_st_e           st;
    logic [CNT_W-1:0]   pat;   // good commas seen while hunting
    logic [CNT_W-1:0]   err;   // outstanding errors while synchronized
    logic [CNT_W-1:0]   run;   // consecutive valid words toward one decrement
  } sync_ctx_t;

  localparam sync_ctx_t CTX_IDLE = '{st: ST_HUNT, pat: '0, err: '0, run: '0};

endpackage

// File: rtl/sync8b10b_classify.sv
module sync8b10b_classify (
  input  logic comma_i,
  input  logic code_ok_i,
  input  logic disp_err_i,
  output logic ev_err_o,
  output logic ev_pat_o
);

  // R2: illegal code or broken disparity both count as an error.
  assign ev_err_o = ~code_ok_i | disp_err_i;
  assign ev_pat_o = comma_i & code_ok_i & ~disp_err_i;

endmodule

// File: rtl/sync8b10b_step.sv
module sync8b10b_step
  import sync8b10b_pkg::*;
#(
  parameter int GAIN_CNT = 3,
  parameter int LOSE_CNT = 3,
  parameter int DEC_CNT  = 3
) (
  input  sync_ctx_t cur_i,
  input  logic      ev_err_i,
  input  logic      ev_pat_i,
  output sync_ctx_t nxt_o
);

  localparam logic [CNT_W:0] GAIN_W = (CNT_W+1)'(GAIN_CNT);
  localparam logic [CNT_W:0] LOSE_W = (CNT_W+1)'(LOSE_CNT);
  localparam logic [CNT_W:0] DEC_W  = (CNT_W+1)'(DEC_CNT);
  localparam logic [CNT_W:0] ONE_W  = (CNT_W+1)'(1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W:0] pat_inc;
  logic [CNT_W:0] err_inc;
  logic [CNT_W:0] run_inc;

  always_comb begin
    pat_inc = {1'b0, cur_i.pat} + ONE_W;
    err_inc = {1'b0, cur_i.err} + ONE_W;
    run_inc = {1'b0, cur_i.run} + ONE_W;
    nxt_o   = cur_i;
    case (cur_i.st)
      ST_HUNT: begin
        if (ev_err_i) begin
          nxt_o.pat = '0;                         // R4
        end else if (ev_pat_i) begin
          if (pat_inc >= GAIN_W) begin            // R3
            nxt_o.st  = ST_LOCK;
            nxt_o.pat = '0;
          end else begin
            nxt_o.pat = pat_inc[CNT_W-1:0];
          end
        end
      end
      default: begin
        if (ev_err_i) begin
          if (err_inc >= LOSE_W) begin
            nxt_o = CTX_IDLE;                     // R6
          end else begin
            nxt_o.st  = ST_ERR;                   // R5
            nxt_o.err = err_inc[CNT_W-1:0];
            nxt_o.run = '0;                       // R8
          end
        end else if (cur_i.st == ST_ERR) begin
          if (run_inc >= DEC_W) begin             // R7
            nxt_o.run = '0;
            nxt_o.err = cur_i.err - ONE;
            if (cur_i.err == ONE) nxt_o.st = ST_LOCK;
          end else begin
            nxt_o.run = run_inc[CNT_W-1:0];
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/sync8b10b_fsm.sv
module sync8b10b_fsm
  import sync8b10b_pkg::*;
#(
  parameter int SYM_PER_CYC = 2,
  parameter int GAIN_CNT    = 3,
  parameter int LOSE_CNT    = 3,
  parameter int DEC_CNT     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SYM_PER_CYC-1:0] sym_comma_i,
  input  logic [SYM_PER_CYC-1:0] sym_code_ok_i,
  input  logic [SYM_PER_CYC-1:0] sym_disp_err_i,
  output logic                   sync_o
);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [SYM_PER_CYC-1:0] err_vec;
  logic [SYM_PER_CYC-1:0] pat_vec;
  sync_ctx_t              chain [SYM_PER_CYC+1];
  sync_ctx_t              ctx_q;
  sync_ctx_t              ctx_d;
  logic                   ctx_en;

  assign chain[0] = ctx_q;

  // R9: lane 0 feeds lane 1, so lower symbols are applied first.
  for (genvar g = 0; g < SYM_PER_CYC; g++) begin : g_lane
    sync8b10b_classify u_cls (
      .comma_i    (sym_comma_i[g]),
      .code_ok_i  (sym_code_ok_i[g]),
      .disp_err_i (sym_disp_err_i[g]),
      .ev_err_o   (err_vec[g]),
      .ev_pat_o   (pat_vec[g])
    );
    sync8b10b_step #(
      .GAIN_CNT (GAIN_CNT),
      .LOSE_CNT (LOSE_CNT),
      .DEC_CNT  (DEC_CNT)
    ) u_step (
      .cur_i    (chain[g]),
      .ev_err_i (err_vec[g]),
      .ev_pat_i (pat_vec[g]),
      .nxt_o    (chain[g+1])
    );
  end

  always_comb begin
    ctx_d  = chain[SYM_PER_CYC];
    ctx_en = (ctx_d != ctx_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctx_q <= CTX_IDLE;        // R1
    else if (ctx_en)  ctx_q <= ctx_d;
  end

  assign sync_o = (ctx_q.st != ST_HUNT);

  // Assertions
  a_r3_rise_needs_pattern: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sync_o) |-> $past(|pat_vec));

  a_r6_fall_needs_error: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(sync_o) |-> $past(|err_vec));

  a_r4_pat_below_gain: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctx_q.st == ST_HUNT) |-> (int'(ctx_q.pat) < GAIN_CNT));

  a_r5_err_below_lose: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctx_q.st != ST_HUNT) |-> (int'(ctx_q.err) < LOSE_CNT));

  a_r7_run_below_dec: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int'(ctx_q.run) < DEC_CNT);

  a_r6_hunt_clean: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctx_q.st == ST_HUNT) |-> (ctx_q.err == '0 && ctx_q.run == '0));

  a_r7_lock_clean: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctx_q.st == ST_LOCK) |-> (ctx_q.err == '0 && ctx_q.run == '0 && ctx_q.pat == '0));

endmodule

// File: tb/sync8b10b_fsm_tb_top.sv
`timescale 1ns/1ps
module sync8b10b_fsm_tb_top;

  // Symbol kinds: D valid data, P comma, E illegal code, X disparity error
  localparam int D = 0;
  localparam int P = 1;
  localparam int E = 2;
  localparam int X = 3;

  logic       clk;
  logic       rst_n;
  logic [1:0] comma;
  logic [1:0] code_ok;
  logic [1:0] disp_err;
  logic       sync_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit    exp;
    string tag;
  } exp_t;
  exp_t q[$];

  // R10: default thresholds 3/3/3, two symbols per cycle
  sync8b10b_fsm #(
    .SYM_PER_CYC (2),
    .GAIN_CNT    (3),
    .LOSE_CNT    (3),
    .DEC_CNT     (3)
  ) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .sym_comma_i    (comma),
    .sym_code_ok_i  (code_ok),
    .sym_disp_err_i (disp_err),
    .sync_o         (sync_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic set_lane(input int lane, input int kind);
    comma[lane]    = (kind == P);
    code_ok[lane]  = (kind != E);
    disp_err[lane] = (kind == X);
  endtask

  // Driver: apply one cycle of symbols and queue the expected sync value.
  task automatic put(input int lo, input int hi, input bit exp, input string tag);
    exp_t it;
    @(negedge clk);
    set_lane(0, lo);
    set_lane(1, hi);
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: sample just after the edge that consumed the queued symbols.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (sync_o !== it.exp) begin
        errors++;
        $display("FAIL %s: sync_o actual %0b expected %0b", it.tag, sync_o, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_lane(0, D);
    set_lane(1, D);
    repeat (3) @(negedge clk);
    checks++;
    if (sync_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: sync_o in reset actual %0b expected 0", sync_o);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (sync_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: sync_o after release actual %0b expected 0", sync_o);
    end

    // Acquisition: non-comma words keep the count
    put(P, P, 0, "R3");
    put(D, D, 0, "R4");
    put(P, D, 1, "R3 R10");
    // Error region and forgiveness
    put(E, D, 1, "R5");
    put(D, D, 1, "R7");
    put(E, E, 1, "R7");
    put(D, X, 0, "R2");
    // Error in hunt clears the pattern count
    put(P, P, 0, "R4");
    put(E, P, 0, "R4");
    put(P, D, 0, "R4");
    put(P, D, 1, "R3");
    // Error restarts the clean run
    put(E, D, 1, "R8");
    put(D, E, 1, "R8");
    put(D, D, 1, "R8");
    put(E, D, 0, "R8");
    // Lane order
    put(P, P, 0, "R9");
    put(P, D, 1, "R9");
    put(E, E, 1, "R5");
    put(E, P, 0, "R9");
    put(P, P, 1, "R9");
    // Full recovery to clean lock, then loss
    put(E, E, 1, "R7");
    put(D, D, 1, "R7");
    put(D, D, 1, "R7");
    put(D, D, 1, "R7");
    put(E, E, 1, "R7");
    put(D, D, 1, "R7");
    put(E, D, 0, "R6");
    // Loss clears everything; disparity-broken comma is not a pattern
    put(P, P, 0, "R6");
    put(X, P, 0, "R2");
    put(P, D, 0, "R2");
    put(P, D, 1, "R2");

    repeat (3) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule